// File: doc/BRIEF.md
# Programmable Tap Binary Timer

A 16-bit synchronous up-counter with a selectable output tap. Two select bits pick one of four stage depths N (8, 10, 13 or 16). In recycle mode the block acts as a divide-by-2^N square-wave generator. In one-shot mode it is a timer: its output changes level once, 2^(N-1) counts after a clear, and then keeps that level.

The block can be cleared in two ways. The first is an active-high master clear. The second is an emulated power-on clear, which runs for a few cycles after the global reset is released unless it has been disabled. While either clear is active, a clock-enable output is held low so that the upstream clock source can be gated off. A polarity input chooses whether the output idles low and rises, or idles high and falls.

Top module: `tap_timer`

## Requirements
- R1: While no clear is active, the counter advances by one, modulo 2^16, on every rising clock edge.
- R2: In recycle mode (`mode`=1), `q_out` is a square wave with period 2^N clocks and a high phase of 2^(N-1) clocks when `pol`=0. After a clear, `q_out` first rises on edge 2^(N-1)+1. `sel` maps to N as follows: 2'b00 gives 13, 2'b01 gives 10, 2'b10 gives 8, 2'b11 gives 16.
- R3: In one-shot mode (`mode`=0), `q_out` toggles away from its post-clear level on the (2^(N-1)+1)-th rising edge after the last edge that sampled a clear.
- R4: In one-shot mode, once the transition has happened `q_out` keeps its new level even when the selected counter bit falls again.
- R5: An edge that samples `mrst`=1 clears the counter and the output latch, so `q_out` equals `pol` afterwards.
- R6: `q_out` equals the internal output state XOR `pol`: with `pol`=0 the output starts low, and with `pol`=1 it starts high and falls at the transition.
- R7: `clk_en` is 0 while `rst_n` is low, while `mrst` is high, or while the power-on clear is active. Otherwise it is 1.
- R8: When `auto_rst_dis`=0, a clear lasting 4 clock edges follows the release of `rst_n`. When `auto_rst_dis`=1, no such clear occurs.
- R9: A change of `sel` takes effect at the next rising edge.
- R10: Setting `mode` to 1 releases a latched one-shot output, so the output follows the selected counter bit again from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst_n | input | 1 | Global synchronous reset, active low |
| mrst | input | 1 | Master clear, active high |
| auto_rst_dis | input | 1 | 1 disables the power-on clear |
| sel | input | 2 | Tap select, bit 1 = A, bit 0 = B |
| pol | input | 1 | Output polarity after a clear |
| mode | input | 1 | 1 = recycle, 0 = one-shot |
| q_out | output | 1 | Timer output |
| clk_en | output | 1 | Clock-source enable, low during any clear |

## Verification
The output register adds one edge after the counter, so a counter value reached on edge k shows up on `q_out` after edge k+1. The bench therefore expects the first transition 2^(N-1)+1 edges after the clearing edge. It reads every result at the falling edge after the rising edge that produced it. `clk_en` is combinational, so it is compared in the same half-cycle as the inputs that drive it. A cycle-accurate behavioural model checks `q_out` and `clk_en` on every clock. Point checks measure the periods, the transition counts, latch hold, release and the effect of a select change.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

    localparam int unsigned TT_CNT_W = 16;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RECYCLE = 1'b1
    } tt_mode_e;

    // Stage depth chosen by the select pair; the pairing is fixed behaviour.
    function automatic int unsigned stage_for_sel(input logic [1:0] sel);
        case (sel)
            2'b00:   return 13;
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/tt_por_gen.sv
module tt_por_gen #(
    parameter int unsigned POR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_dis,
    output logic por_o
);
    localparam int unsigned PW = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } por_st_t;

    por_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0) st_d.left = st_q.left - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.left <= PW'(POR_CYCLES);
        else        st_q      <= st_d;
    end

    assign por_o = (st_q.left != '0) && !auto_dis;

    AST_POR_EXPIRED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left == '0) |=> (st_q.left == '0)); // R8

    AST_POR_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left != '0) |=> (st_q.left < $past(st_q.left))); // R8
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.cnt = '0;
        else     st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_o == '0)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1)))); // R1
endmodule

// File: rtl/tt_tap_out.sv
module tt_tap_out
    import tap_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       sel,
    input  logic             mode,
    output logic             raw_o
);
    localparam int unsigned IW = $clog2(CNT_W);

    typedef struct packed {
        logic raw;
    } out_st_t;

    out_st_t     st_d, st_q;
    logic [IW-1:0] tap_idx;
    logic          tap;

    assign tap_idx = IW'(stage_for_sel(sel) - 1);
    assign tap     = cnt_i[tap_idx];

    always_comb begin
        st_d = st_q;
        if (clr)                       st_d.raw = 1'b0;
        else if (mode == MODE_RECYCLE) st_d.raw = tap;
        else                           st_d.raw = st_q.raw | tap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.raw <= 1'b0;
        else        st_q     <= st_d;
    end

    assign raw_o = st_q.raw;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONESHOT && raw_o && !clr) |=> raw_o); // R4

    AST_RISE_FROM_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_o) |-> $past(tap)); // R3

    AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !raw_o); // R5
endmodule

// File: rtl/tap_timer.sv
module tap_timer
    import tap_timer_pkg::*;
#(
    parameter int unsigned CNT_W      = TT_CNT_W,
    parameter int unsigned POR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mrst,
    input  logic       auto_rst_dis,
    input  logic [1:0] sel,
    input  logic       pol,
    input  logic       mode,
    output logic       q_out,
    output logic       clk_en
);
    logic             por_rst;
    logic             clr;
    logic [CNT_W-1:0] cnt;
    logic             raw;

    tt_por_gen #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_dis (auto_rst_dis),
        .por_o    (por_rst)
    );

    assign clr = mrst | por_rst;

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .cnt_o (cnt)
    );

    tt_tap_out #(.CNT_W(CNT_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .cnt_i (cnt),
        .sel   (sel),
        .mode  (mode),
        .raw_o (raw)
    );

    assign q_out  = raw ^ pol;
    assign clk_en = rst_n & ~clr;

    AST_CLKEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mrst || por_rst) |-> !clk_en); // R7

    AST_POL_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mrst && $stable(pol)) |=> (q_out == pol)); // R6
endmodule

// File: tb/tap_timer_tb_top.sv
`timescale 1ns/1ps
module tap_timer_tb_top;
    localparam int POR = 4;

    logic       clk = 1'b0;
    logic       rst_n, mrst, auto_rst_dis, pol, mode;
    logic [1:0] sel;
    logic       q_out, clk_en;

    int n_chk  = 0;
    int n_fail = 0;
    longint cyc = 0;
    longint t0  = 0;
    bit cmp_en  = 1'b0;

    // behavioural reference state
    int m_cnt = 0;
    int m_raw = 0;
    int m_por = POR;

    always #2.5 clk = ~clk;

    tap_timer dut_i (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .auto_rst_dis(auto_rst_dis),
        .sel(sel), .pol(pol), .mode(mode), .q_out(q_out), .clk_en(clk_en)
    );

    function automatic int n_of(input logic [1:0] s);
        case (s)
            2'b00:   return 13;
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_clr();
        return mrst || (m_por != 0 && !auto_rst_dis);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_cnt = 0; m_raw = 0; m_por = POR;
        end else begin
            int tapv;
            tapv = (m_cnt >> (n_of(sel) - 1)) & 1;
            if (model_clr()) begin
                m_cnt = 0; m_raw = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 65536;
                m_raw = mode ? tapv : (m_raw | tapv);
            end
            if (m_por != 0) m_por = m_por - 1;
        end
    end

    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            int eq, ec;
            eq = m_raw ^ int'(pol);
            ec = (rst_n && !model_clr()) ? 1 : 0;
            chk(q_out == eq[0], "R2 per-cycle q_out", q_out, eq);
            chk(clk_en == ec[0], "R7 per-cycle clk_en", clk_en, ec);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    task automatic pulse_mrst();
        @(negedge clk); mrst = 1'b1;
        @(negedge clk);
        chk(q_out == pol, "R5 output after master clear", q_out, pol);
        chk(clk_en == 1'b0, "R7 clk_en during master clear", clk_en, 0);
        mrst = 1'b0;
        t0 = cyc;
    endtask

    task automatic wait_level(input logic lvl);
        while (q_out != lvl) @(negedge clk);
    endtask

    task automatic run_recycle(input logic [1:0] s);
        longint tr1, tf, tr2;
        int n;
        n = n_of(s);
        sel = s; mode = 1'b1; pol = 1'b0;
        pulse_mrst();
        wait_level(1'b1); tr1 = cyc;
        chk(tr1 - t0 == 2**(n-1) + 1, "R2 first rise", tr1 - t0, 2**(n-1) + 1);
        wait_level(1'b0); tf = cyc;
        chk(tf - tr1 == 2**(n-1), "R2 high phase", tf - tr1, 2**(n-1));
        wait_level(1'b1); tr2 = cyc;
        chk(tr2 - tr1 == 2**n, "R2 period", tr2 - tr1, 2**n);
    endtask

    task automatic run_single(input logic [1:0] s, input logic p);
        int n;
        n = n_of(s);
        sel = s; mode = 1'b0; pol = p;
        pulse_mrst();
        chk(q_out == p, "R6 initial level", q_out, p);
        wait_level(~p);
        chk(cyc - t0 == 2**(n-1) + 1, "R3 one-shot transition edge", cyc - t0, 2**(n-1) + 1);
    endtask

    initial begin
        rst_n = 1'b0; mrst = 1'b0; auto_rst_dis = 1'b0;
        sel = 2'b10; pol = 1'b0; mode = 1'b1;
        repeat (3) @(negedge clk);
        chk(clk_en == 1'b0, "R7 clk_en in global reset", clk_en, 0);
        chk(q_out == 1'b0, "R5 reset state q_out", q_out, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        chk(clk_en == 1'b0, "R8 power-on clear active", clk_en, 0);
        repeat (3) @(negedge clk);
        chk(clk_en == 1'b1, "R8 power-on clear ended", clk_en, 1);

        run_recycle(2'b10);
        run_recycle(2'b01);
        run_recycle(2'b00);
        run_recycle(2'b11);

        // R9: tap change takes effect on the next edge
        sel = 2'b10; mode = 1'b1; pol = 1'b0;
        pulse_mrst();
        repeat (200) @(negedge clk);
        chk(q_out == 1'b1, "R9 before select change", q_out, 1);
        sel = 2'b01;
        @(negedge clk);
        chk(q_out == 1'b0, "R9 after select change", q_out, 0);

        // one-shot, polarity 0, then hold and release
        run_single(2'b10, 1'b0);
        while (cyc - t0 < 300) @(negedge clk);
        chk(q_out == 1'b1, "R4 latched level held", q_out, 1);
        mode = 1'b1;
        @(negedge clk);
        chk(q_out == 1'b0, "R10 latch released by mode", q_out, 0);

        // R1: counter advancing, seen on an intermediate tap bit
        run_single(2'b01, 1'b1);
        chk(q_out == 1'b0, "R6 polarity 1 falls", q_out, 0);
        chk(cyc - t0 == 513, "R1 count reached tap", cyc - t0, 513);

        // R8: auto-clear disabled
        rst_n = 1'b0; auto_rst_dis = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_en == 1'b1, "R8 no power-on clear when disabled", clk_en, 1);
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule